// File: doc/BRIEF.md
# Downstream Port Reset Output Controller

This block produces the active-low reset signal for each downstream port of a switch. Each signal goes out to an external hot-plug I/O expander. One mode input applies to all ports and picks what drives the reset. In power-enable mode, the port's slot power command drives it. In power-good mode, a per-port power-good input drives it, after that input has passed through a synchronizer.

Two event pulses can also force the reset low in either mode. One marks a fundamental reset of the port's partition. The other marks an operating-mode change whose action is set to reset. Every assertion lasts at least a minimum number of clock cycles. A fresh assertion cause restarts that minimum window. Once the selected power source is good again, the reset is released after a separate settling delay. Both durations are parameters counted in clock cycles. Each port runs independently of the others.

Top module: `port_rst_top`

## Requirements
- R1: While `rst_n` is low, every bit of `portRstN` is 0. After `rst_n` rises, every bit stays 0 for MIN_PULSE clock edges and then goes to 1, provided no port has an assertion cause.
- R2: `modeSel` selects the reset source for all ports at once. 0 selects power-enable mode and 1 selects power-good mode.
- R3: In power-enable mode, `slotPwrOn[i]`=0 drives `portRstN[i]` to 0 from the next clock edge onward. If the minimum window has already expired, the output returns to 1 on the REL_DELAY-th edge that samples `slotPwrOn[i]`=1, counting the first such edge.
- R4: In power-good mode, `pwrGood[i]` passes through two flops before use. A low synchronized value holds `portRstN[i]` at 0. After `pwrGood[i]` rises, the output returns to 1 on the (REL_DELAY+2)-th edge, counting the first edge that sees the new input level.
- R5: The source that the mode does not select has no effect. In power-good mode, `slotPwrOn` is ignored. In power-enable mode, `pwrGood` is ignored.
- R6: A one-cycle pulse on `fundRst[i]` drives `portRstN[i]` to 0 from the next edge, in either mode.
- R7: A one-cycle pulse on `opRst[i]` drives `portRstN[i]` to 0 from the next edge, in either mode.
- R8: Every assertion of `portRstN[i]` lasts at least MIN_PULSE cycles. A lone event pulse, or a slot-power glitch of a single cycle, gives a low time of exactly MIN_PULSE cycles when MIN_PULSE is larger than REL_DELAY.
- R9: An event pulse that arrives while the reset is already asserted restarts the minimum window, so release comes MIN_PULSE edges after the later pulse.
- R10: Inputs for one port never change the output of another port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Block reset, active low, asynchronous |
| modeSel | input | 1 | Reset source select: 0 = power-enable, 1 = power-good |
| slotPwrOn | input | NUM_PORTS | Slot power command per port, 1 = power on |
| pwrGood | input | NUM_PORTS | Asynchronous power-good per port, 1 = good |
| fundRst | input | NUM_PORTS | Partition fundamental reset pulse per port |
| opRst | input | NUM_PORTS | Operating-mode change with reset action, pulse per port |
| portRstN | output | NUM_PORTS | Port reset output, active low |

## Verification
A long power-off followed by power-on shows the settling delay on its own. A single-cycle power-off glitch and a lone event pulse show the minimum-width path on its own. The two release counts differ, so a mix-up between the two counters shows up. The power-good release count is two edges longer than the power-enable count, which confirms the synchronizer depth. Toggling the unselected source in each mode shows that the mode gating works. A second event placed inside a running assertion separates reloading the minimum window from letting it run down. Idle ports are watched throughout to catch crosstalk between ports.

// File: rtl/port_rst_pkg.sv
package port_rst_pkg;
  typedef struct packed {
    logic holdReq;   // selected power source says "keep in reset"
    logic loadMin;   // a new assertion cause: restart minimum window
  } rst_strobe_t;
endpackage

// File: rtl/port_rst_sync.sv
module port_rst_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1  <= '0;
      syncOut <= '0;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/port_rst_ctl.sv
module port_rst_ctl
  import port_rst_pkg::*;
(
  input  logic        modeSel,
  input  logic        slotPwrOn,
  input  logic        pgSync,
  input  logic        fundRst,
  input  logic        opRst,
  input  logic        rstOn,
  output rst_strobe_t strobe
);
  logic holdSrc;

  always_comb begin
    holdSrc        = modeSel ? !pgSync : !slotPwrOn;
    strobe.holdReq = holdSrc;
    // fresh cause: either event, or the source starting a new assertion
    strobe.loadMin = fundRst | opRst | (holdSrc & !rstOn);
  end
endmodule

// File: rtl/port_rst_dp.sv
module port_rst_dp
  import port_rst_pkg::*;
#(
  parameter int MIN_PULSE = 50000,
  parameter int REL_DELAY = 250,
  localparam int CNT_MAX  = (MIN_PULSE > REL_DELAY) ? MIN_PULSE : REL_DELAY,
  localparam int CNT_W    = $clog2(CNT_MAX + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  rst_strobe_t strobe,
  output logic        rstOn
);
  logic [CNT_W-1:0] minCnt, minNext;
  logic [CNT_W-1:0] relCnt, relNext;
  logic             rstNext;

  always_comb begin
    if (strobe.loadMin)     minNext = CNT_W'(MIN_PULSE);
    else if (minCnt != '0)  minNext = minCnt - 1'b1;
    else                    minNext = '0;

    if (strobe.holdReq)     relNext = CNT_W'(REL_DELAY);
    else if (relCnt != '0)  relNext = relCnt - 1'b1;
    else                    relNext = '0;

    rstNext = strobe.holdReq | strobe.loadMin | (minNext != '0) | (relNext != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      minCnt <= CNT_W'(MIN_PULSE);
      relCnt <= '0;
      rstOn  <= 1'b1;
    end else begin
      minCnt <= minNext;
      relCnt <= relNext;
      rstOn  <= rstNext;
    end
  end
endmodule

// File: rtl/port_rst_top.sv
module port_rst_top
  import port_rst_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int MIN_PULSE = 50000,
  parameter int REL_DELAY = 250
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 modeSel,
  input  logic [NUM_PORTS-1:0] slotPwrOn,
  input  logic [NUM_PORTS-1:0] pwrGood,
  input  logic [NUM_PORTS-1:0] fundRst,
  input  logic [NUM_PORTS-1:0] opRst,
  output logic [NUM_PORTS-1:0] portRstN
);
  logic [NUM_PORTS-1:0] pgSync;
  logic [NUM_PORTS-1:0] rstOn;

  port_rst_sync #(.WIDTH(NUM_PORTS)) u_sync (
    .clk(clk), .rst_n(rst_n), .asyncIn(pwrGood), .syncOut(pgSync)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    rst_strobe_t strobe;

    port_rst_ctl u_ctl (
      .modeSel(modeSel), .slotPwrOn(slotPwrOn[p]), .pgSync(pgSync[p]),
      .fundRst(fundRst[p]), .opRst(opRst[p]), .rstOn(rstOn[p]),
      .strobe(strobe)
    );

    port_rst_dp #(.MIN_PULSE(MIN_PULSE), .REL_DELAY(REL_DELAY)) u_dp (
      .clk(clk), .rst_n(rst_n), .strobe(strobe), .rstOn(rstOn[p])
    );
  end

  assign portRstN = ~rstOn;
endmodule

// File: rtl/port_rst_chk.sv
module port_rst_chk #(
  parameter int NUM_PORTS = 4,
  parameter int MIN_PULSE = 50000,
  localparam int LW = $clog2(MIN_PULSE + 2)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 modeSel,
  input logic [NUM_PORTS-1:0] slotPwrOn,
  input logic [NUM_PORTS-1:0] pgSync,
  input logic [NUM_PORTS-1:0] fundRst,
  input logic [NUM_PORTS-1:0] opRst,
  input logic [NUM_PORTS-1:0] portRstN
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    logic [LW-1:0] lowCnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lowCnt <= '0;
      else if (portRstN[p]) lowCnt <= '0;
      else if (lowCnt != LW'(MIN_PULSE + 1)) lowCnt <= lowCnt + 1'b1;
    end

    p_pe_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!modeSel && !slotPwrOn[p]) |=> !portRstN[p]);

    p_pg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (modeSel && !pgSync[p]) |=> !portRstN[p]);

    p_fund_rst_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fundRst[p] |=> !portRstN[p]);

    p_op_rst_r7: assert property (@(posedge clk) disable iff (!rst_n)
      opRst[p] |=> !portRstN[p]);

    p_min_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (portRstN[p] && !$past(portRstN[p])) |-> (lowCnt >= LW'(MIN_PULSE)));
  end
endmodule

bind port_rst_top port_rst_chk #(.NUM_PORTS(NUM_PORTS), .MIN_PULSE(MIN_PULSE)) u_chk (
  .clk(clk), .rst_n(rst_n), .modeSel(modeSel), .slotPwrOn(slotPwrOn),
  .pgSync(pgSync), .fundRst(fundRst), .opRst(opRst), .portRstN(portRstN)
);

// File: tb/port_rst_top_tb.sv
module port_rst_top_tb;
  localparam int NP  = 4;
  localparam int MIN = 12;
  localparam int REL = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          modeSel = 1'b0;
  logic [NP-1:0] slotPwrOn = '1;
  logic [NP-1:0] pwrGood = '1;
  logic [NP-1:0] fundRst = '0;
  logic [NP-1:0] opRst = '0;
  logic [NP-1:0] portRstN;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  port_rst_top #(.NUM_PORTS(NP), .MIN_PULSE(MIN), .REL_DELAY(REL)) u_dut (
    .clk(clk), .rst_n(rst_n), .modeSel(modeSel), .slotPwrOn(slotPwrOn),
    .pwrGood(pwrGood), .fundRst(fundRst), .opRst(opRst), .portRstN(portRstN)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // counts edges until port goes high, continuing from n
  task automatic countRel(input int p, inout int n);
    for (int k = 0; k < 200; k++) begin
      if (portRstN[p]) return;
      step();
      n++;
    end
  endtask

  task automatic idle(input int cyc);
    for (int k = 0; k < cyc; k++) step();
  endtask

  task automatic t_reset();
    int n = 0;
    chk(portRstN == '0, "R1 reset low", int'(portRstN), 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(); n = 1;
    countRel(0, n);
    chk(n == MIN, "R1 release count", n, MIN);
    chk(portRstN == '1, "R1 all released", int'(portRstN), 15);
  endtask

  task automatic t_pe_long();
    int n = 0;
    slotPwrOn[0] = 1'b0;
    idle(MIN + 10);
    chk(portRstN[0] == 1'b0, "R3 held while off", int'(portRstN[0]), 0);
    chk(portRstN[3:1] == 3'b111, "R10 others high", int'(portRstN[3:1]), 7);
    slotPwrOn[0] = 1'b1;
    step(); n = 1;
    countRel(0, n);
    chk(n == REL, "R3 settle count", n, REL);
  endtask

  task automatic t_pe_glitch();
    int n = 0;
    slotPwrOn[1] = 1'b0;
    step(); n = 1;
    slotPwrOn[1] = 1'b1;
    chk(portRstN[1] == 1'b0, "R8 glitch asserts", int'(portRstN[1]), 0);
    countRel(1, n);
    chk(n == MIN + 1, "R8 glitch width", n, MIN + 1);
  endtask

  task automatic t_pg();
    int n = 0;
    modeSel = 1'b1;
    pwrGood[2] = 1'b0;
    idle(MIN + 10);
    chk(portRstN[2] == 1'b0, "R4 held while not good", int'(portRstN[2]), 0);
    pwrGood[2] = 1'b1;
    step(); n = 1;
    countRel(2, n);
    chk(n == REL + 2, "R4 sync plus settle", n, REL + 2);
  endtask

  task automatic t_ignore();
    int lowSeen = 0;
    modeSel = 1'b1;
    slotPwrOn[2] = 1'b0;
    for (int k = 0; k < 20; k++) begin
      step();
      if (!portRstN[2]) lowSeen++;
    end
    slotPwrOn[2] = 1'b1;
    chk(lowSeen == 0, "R5 power-good mode ignores slot power", lowSeen, 0);
    modeSel = 1'b0;
    pwrGood[3] = 1'b0;
    lowSeen = 0;
    for (int k = 0; k < 20; k++) begin
      step();
      if (!portRstN[3]) lowSeen++;
    end
    pwrGood[3] = 1'b1;
    idle(4);
    chk(lowSeen == 0, "R5 power-enable mode ignores power good", lowSeen, 0);
    chk(portRstN == '1, "R2 mode switch clean", int'(portRstN), 15);
  endtask

  task automatic t_event(input int p, input bit useOp, input bit mode, input string req);
    int n = 0;
    int othersLow = 0;
    modeSel = mode;
    if (useOp) opRst[p] = 1'b1; else fundRst[p] = 1'b1;
    step(); n = 1;
    opRst = '0; fundRst = '0;
    chk(portRstN[p] == 1'b0, req, int'(portRstN[p]), 0);
    for (int k = 0; k < 200 && !portRstN[p]; k++) begin
      for (int q = 0; q < NP; q++) if (q != p && !portRstN[q]) othersLow++;
      step(); n++;
    end
    chk(n == MIN + 1, "R8 event width", n, MIN + 1);
    chk(othersLow == 0, "R10 no crosstalk", othersLow, 0);
    modeSel = 1'b0;
    idle(3);
  endtask

  task automatic t_reload();
    int n = 0;
    fundRst[0] = 1'b1;
    step(); n = 1;
    fundRst[0] = 1'b0;
    for (int k = 0; k < 4; k++) begin step(); n++; end
    opRst[0] = 1'b1;
    step(); n++;
    opRst[0] = 1'b0;
    countRel(0, n);
    chk(n == MIN + 6, "R9 reload window", n, MIN + 6);
  endtask

  initial begin
    fork
      begin
        idle(3);
        t_reset();
        idle(3);
        t_pe_long();
        idle(3);
        t_pe_glitch();
        idle(3);
        t_pg();
        idle(3);
        t_ignore();
        t_event(1, 1'b0, 1'b0, "R6 fundamental reset asserts");
        t_event(3, 1'b1, 1'b1, "R7 mode-change reset asserts");
        t_reload();
      end
      begin
        idle(20000);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule